// File: doc/BRIEF.md
# Per-Rank DRAM Power-Down Controller

This block drives one clock-enable line for each rank on a DRAM channel. Each rank has its own idle timer. The timer restarts whenever a transaction for that rank arrives, or while the rank's queue holds work. When the timer reaches a programmed threshold and nothing is waiting for the rank, the rank's clock enable is dropped and the rank enters the power-down mode selected by the configuration word.

Two power-down flavours are offered:
- **Active power-down** keeps open pages. Its exit is short.
- **Precharge power-down with DLL off** saves the most power. A rank is put into this mode only once its pages are closed. On exit, data transfers must wait a second, longer delay.

After an exit, the block reports separately when a command may be issued and when data may move. The scheduler reads these per-rank flags.

All clock enables stay low through reset and remain low until software strobes configuration-done. For example, the word 0x6080 selects precharge/DLL-off with a 128-cycle idle threshold. The configuration word is sampled live, so it may be changed at run time.

Top module: `rank_pdn_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until the first `cfg_done_i` strobe, every bit of `cke_o`, `cmd_ok_o` and `data_ok_o` is 0. At the clock edge that samples the strobe, all three go to 1 for every rank.
- R2: An arrival on `arrival_i[r]` restarts rank r's idle count. Take the edge that sampled the last arrival (or the last high `q_ne_i[r]`) with `cfg_word_i[7:0]` = T > 0 and an entry-capable mode. `cke_o[r]` stays 1 through the T-th following edge and falls at edge T+1.
- R3: A rank never enters power-down while its `q_ne_i` or `arrival_i` bit is 1.
- R4: An idle threshold of 0 (`cfg_word_i[7:0]` = 0) prevents power-down entry on every rank.
- R5: `cfg_word_i[15:12]` selects the mode: 0 means none, 1 means active power-down, 6 means precharge/DLL-off, and any other code behaves as none. In the none setting, `cke_o` stays 1 after configuration. A rank that is already powered down wakes at the next edge.
- R6: In active power-down mode, a rank enters power-down even while `open_page_i[r]` is 1.
- R7: In precharge/DLL-off mode, a rank with `open_page_i[r]` = 1 does not enter power-down. It enters at the edge after the flag clears, provided the idle threshold is already met.
- R8: An arrival to a powered-down rank raises `cke_o[r]` at the sampling edge. `cmd_ok_o[r]` stays 0 for TXP_CYC edges after that edge and rises at edge TXP_CYC.
- R9: After an exit from active power-down, `data_ok_o[r]` rises together with `cmd_ok_o[r]`. After an exit from precharge/DLL-off, it rises TXPDLL_CYC edges after the wake edge. `data_ok_o` is never 1 while `cmd_ok_o` is 0.
- R10: Ranks are independent. Waking one rank leaves the clock enable of every other rank unchanged.
- R11: Asserting `rst_ni` low forces every `cke_o` bit to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DRAM controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arrival_i | input | NUM_RANKS | Per-rank transaction-arrival strobe |
| q_ne_i | input | NUM_RANKS | Per-rank queue-not-empty flag |
| open_page_i | input | NUM_RANKS | Per-rank open-page flag |
| cfg_word_i | input | 16 | [15:12] mode code, [7:0] idle threshold in cycles |
| cfg_done_i | input | 1 | One-cycle configuration-done strobe |
| cke_o | output | NUM_RANKS | Per-rank clock-enable level |
| cmd_ok_o | output | NUM_RANKS | Per-rank command-issue permitted |
| data_ok_o | output | NUM_RANKS | Per-rank data transfer permitted |

## Verification
Several properties are checked on every cycle:
- a busy or page-holding rank never drops its clock enable;
- a wake always reopens the clock enable with commands still blocked;
- the idle and exit counters step as intended;
- data permission never precedes command permission.

Some behaviours need directed scenarios in the bench:
- the exact entry edge after the idle threshold;
- the lengths of the short and the DLL-relock exit windows;
- the effect of changing the mode at run time;
- independence between ranks;
- the asynchronous effect of reset.

// File: rtl/pdn_pkg.sv
`timescale 1ns/1ps
package pdn_pkg;
  localparam int CFG_W  = 16;
  localparam int THR_W  = 8;
  localparam int MODE_W = 4;

  typedef enum logic [1:0] {PM_NONE, PM_ACTIVE, PM_PRECHG} pdn_mode_e;
  typedef enum logic [1:0] {ST_INIT, ST_ACTIVE, ST_PDN, ST_EXIT} pdn_state_e;

  function automatic pdn_mode_e decode_mode(input logic [MODE_W-1:0] code);
    case (code)
      4'd1:    return PM_ACTIVE;
      4'd6:    return PM_PRECHG;
      default: return PM_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pdn_idle_timer.sv
`timescale 1ns/1ps
module pdn_idle_timer #(
  parameter int THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             expired_o
);
  localparam logic [THR_W-1:0] CNT_MAX = '1;

  logic [THR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (busy_i)           cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // zero threshold disables entry
  assign expired_o = (thr_i != '0) && (cnt_q >= thr_i);

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (cnt_q == '0));

  a_r2_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pdn_exit_timer.sv
`timescale 1ns/1ps
module pdn_exit_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r8_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r8_load_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i != '0) |=> !done_o);
endmodule

// File: rtl/pdn_rank_fsm.sv
`timescale 1ns/1ps
module pdn_rank_fsm
  import pdn_pkg::*;
#(
  parameter int TXP_CYC    = 4,
  parameter int TXPDLL_CYC = 12,
  parameter int TW         = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cfg_done_i,
  input  logic      arrival_i,
  input  logic      q_ne_i,
  input  logic      open_page_i,
  input  pdn_mode_e mode_i,
  input  logic      expired_i,
  output logic      cke_o,
  output logic      cmd_ok_o,
  output logic      data_ok_o
);
  localparam logic [TW-1:0] TXP_V    = TW'(TXP_CYC);
  localparam logic [TW-1:0] TXPDLL_V = TW'(TXPDLL_CYC);

  pdn_state_e st_q, st_d;
  logic       dll_off_q;
  logic       wake, enter, load;
  logic       cmd_done, data_done;

  assign wake  = arrival_i | q_ne_i | (mode_i == PM_NONE);
  assign enter = (mode_i != PM_NONE) && expired_i && !arrival_i && !q_ne_i
               && !(mode_i == PM_PRECHG && open_page_i);
  assign load  = (st_q == ST_PDN) && wake;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_INIT:   if (cfg_done_i)             st_d = ST_ACTIVE;
      ST_ACTIVE: if (enter)                  st_d = ST_PDN;
      ST_PDN:    if (wake)                   st_d = ST_EXIT;
      ST_EXIT:   if (cmd_done && data_done)  st_d = ST_ACTIVE;
      default:                               st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_INIT;
      dll_off_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_ACTIVE && enter) dll_off_q <= (mode_i == PM_PRECHG);
    end
  end

  pdn_exit_timer #(.W(TW)) u_cmd_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (TXP_V),
    .done_o     (cmd_done)
  );

  pdn_exit_timer #(.W(TW)) u_data_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (dll_off_q ? TXPDLL_V : TXP_V),
    .done_o     (data_done)
  );

  assign cke_o     = (st_q == ST_ACTIVE) || (st_q == ST_EXIT);
  assign cmd_ok_o  = (st_q == ST_ACTIVE) || (st_q == ST_EXIT && cmd_done);
  assign data_ok_o = (st_q == ST_ACTIVE) || (st_q == ST_EXIT && data_done);

  a_r1_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INIT && !cfg_done_i) |=> !cke_o);

  a_r3_busy_stays_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACTIVE && (q_ne_i || arrival_i)) |=> cke_o);

  a_r5_none_stays_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_INIT && mode_i == PM_NONE) |=> cke_o);

  a_r7_open_page_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACTIVE && mode_i == PM_PRECHG && open_page_i) |=> cke_o);

  a_r8_wake_blocks_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PDN && arrival_i) |=> (cke_o && !cmd_ok_o));

  a_r9_data_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ok_o |-> cmd_ok_o);

  a_r9_dll_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && dll_off_q) |=> !data_ok_o);
endmodule

// File: rtl/rank_pdn_ctrl.sv
`timescale 1ns/1ps
module rank_pdn_ctrl
  import pdn_pkg::*;
#(
  parameter int NUM_RANKS  = 4,
  parameter int TXP_CYC    = 4,
  parameter int TXPDLL_CYC = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_RANKS-1:0] arrival_i,
  input  logic [NUM_RANKS-1:0] q_ne_i,
  input  logic [NUM_RANKS-1:0] open_page_i,
  input  logic [15:0]          cfg_word_i,
  input  logic                 cfg_done_i,
  output logic [NUM_RANKS-1:0] cke_o,
  output logic [NUM_RANKS-1:0] cmd_ok_o,
  output logic [NUM_RANKS-1:0] data_ok_o
);
  localparam int DLY_MAX = (TXPDLL_CYC > TXP_CYC) ? TXPDLL_CYC : TXP_CYC;
  localparam int TW      = $clog2(DLY_MAX + 1);

  pdn_mode_e        mode;
  logic [THR_W-1:0] thr;
  logic             unused_cfg;

  assign mode       = decode_mode(cfg_word_i[CFG_W-1 -: MODE_W]);
  assign thr        = cfg_word_i[THR_W-1:0];
  assign unused_cfg = ^cfg_word_i[CFG_W-MODE_W-1:THR_W];

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic expired;

    pdn_idle_timer #(.THR_W(THR_W)) u_idle (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .busy_i    (arrival_i[r] | q_ne_i[r]),
      .thr_i     (thr),
      .expired_o (expired)
    );

    pdn_rank_fsm #(
      .TXP_CYC    (TXP_CYC),
      .TXPDLL_CYC (TXPDLL_CYC),
      .TW         (TW)
    ) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_done_i  (cfg_done_i),
      .arrival_i   (arrival_i[r]),
      .q_ne_i      (q_ne_i[r]),
      .open_page_i (open_page_i[r]),
      .mode_i      (mode),
      .expired_i   (expired),
      .cke_o       (cke_o[r]),
      .cmd_ok_o    (cmd_ok_o[r]),
      .data_ok_o   (data_ok_o[r])
    );
  end

  a_r11_reset_low: assert property (@(posedge clk_i) !rst_ni |-> (cke_o == '0));
endmodule

// File: tb/tb_rank_pdn_ctrl.sv
`timescale 1ns/1ps
module tb_rank_pdn_ctrl;
  localparam int N      = 4;
  localparam int TXP    = 4;
  localparam int TXPDLL = 12;
  localparam int THR    = 5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] arr = '0, qne = '0, opg = '0;
  logic [15:0]  cfg = 16'h6005;
  logic         cfg_done = 1'b0;
  logic [N-1:0] cke, cmd_ok, data_ok;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  rank_pdn_ctrl #(.NUM_RANKS(N), .TXP_CYC(TXP), .TXPDLL_CYC(TXPDLL)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .arrival_i(arr), .q_ne_i(qne),
    .open_page_i(opg), .cfg_word_i(cfg), .cfg_done_i(cfg_done),
    .cke_o(cke), .cmd_ok_o(cmd_ok), .data_ok_o(data_ok));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_arr(input logic [N-1:0] m);
    arr = m; tick(1); arr = '0;
  endtask

  task automatic all_down();
    pulse_arr('1);
    tick(THR + 1);
  endtask

  task automatic t_init();
    qne = '1;
    #1;
    chk("R1 reset cke", cke, '0);
    chk("R1 reset cmd", cmd_ok, '0);
    rst_ni = 1'b1;
    tick(3);
    chk("R1 no cfg yet", cke, '0);
    chk("R1 no cfg data", data_ok, '0);
    cfg_done = 1'b1; tick(1); cfg_done = 1'b0;
    chk("R1 cfg cke", cke, '1);
    chk("R1 cfg data", data_ok, '1);
    qne = '0;
  endtask

  task automatic t_entry();
    tick(THR);
    chk("R2 before threshold", cke, '1);
    tick(1);
    chk("R2 at threshold", cke, '0);
    chk("R2 cmd blocked", cmd_ok, '0);
  endtask

  task automatic t_wake_ppd();
    pulse_arr(4'b0001);
    chk1("R8 cke up", cke[0], 1'b1);
    chk1("R8 cmd low", cmd_ok[0], 1'b0);
    chk("R10 others down", cke[3:1], 3'b000);
    tick(TXP - 1);
    chk1("R8 cmd still low", cmd_ok[0], 1'b0);
    tick(1);
    chk1("R8 cmd up", cmd_ok[0], 1'b1);
    chk1("R9 ppd data low", data_ok[0], 1'b0);
    tick(TXPDLL - TXP - 1);
    chk1("R9 ppd data before", data_ok[0], 1'b0);
    tick(1);
    chk1("R9 ppd data up", data_ok[0], 1'b1);
  endtask

  task automatic t_busy();
    all_down();
    arr[1] = 1'b1; tick(1); arr[1] = 1'b0; qne[1] = 1'b1;
    tick(20);
    chk1("R3 queue busy keeps cke", cke[1], 1'b1);
    chk("R10 others stay down", {cke[3:2], cke[0]}, 3'b000);
    qne[1] = 1'b0;
    tick(THR);
    chk1("R2 after queue drains", cke[1], 1'b1);
    tick(1);
    chk1("R2 entry after drain", cke[1], 1'b0);
  endtask

  task automatic t_open_page();
    opg[2] = 1'b1;
    pulse_arr(4'b0100);
    tick(20);
    chk1("R7 open page blocks entry", cke[2], 1'b1);
    opg[2] = 1'b0;
    tick(1);
    chk1("R7 entry after close", cke[2], 1'b0);
  endtask

  task automatic t_apd();
    cfg = 16'h1005;
    opg[2] = 1'b1;
    pulse_arr(4'b0100);
    tick(30);
    chk1("R6 apd with open page", cke[2], 1'b0);
    pulse_arr(4'b0100);
    chk1("R9 apd data low", data_ok[2], 1'b0);
    tick(TXP - 1);
    chk1("R9 apd data before", data_ok[2], 1'b0);
    tick(1);
    chk1("R9 apd data with cmd", data_ok[2] & cmd_ok[2], 1'b1);
    opg[2] = 1'b0;
  endtask

  task automatic t_zero_thr();
    cfg = 16'h6000;
    pulse_arr('1);
    tick(40);
    chk("R4 zero threshold", cke, '1);
  endtask

  task automatic t_none();
    cfg = 16'h6005;
    all_down();
    chk("R5 precondition down", cke, '0);
    cfg = 16'h0005;
    tick(1);
    chk("R5 none wakes", cke, '1);
    tick(30);
    chk("R5 none stays up", cke, '1);
    cfg = 16'h3005;
    tick(30);
    chk("R5 unknown code as none", cke, '1);
  endtask

  task automatic t_reset();
    cfg = 16'h6005;
    #1 rst_ni = 1'b0;
    #1;
    chk("R11 async reset", cke, '0);
    chk("R11 async reset cmd", cmd_ok, '0);
    tick(1);
    rst_ni = 1'b1;
    tick(5);
    chk("R1 after reset waits cfg", cke, '0);
    cfg_done = 1'b1; tick(1); cfg_done = 1'b0;
    chk("R1 up after cfg", cke, '1);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_init();
    pulse_arr('1);
    t_entry();
    t_wake_ppd();
    t_busy();
    t_open_page();
    t_apd();
    t_zero_thr();
    t_none();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule